// File: doc/BRIEF.md
# Hashed Cached-Region Counter Array

This block keeps a compact, conservative record of which memory regions have at least one block in the local cache. A region is an aligned, power-of-two area of memory. Its tag is the address with the low lg(region size) offset bits removed. The tag is XOR-folded down to an index into a table of up/down counters.

When the cache allocates a block, the counter at that block's index goes up by one. When the cache evicts a block, that counter goes down by one. Several regions share one counter, so a non-zero counter can belong to a region that holds nothing. This gives a false positive, which only loses an opportunity to skip a snoop. A region that holds a block always sees a non-zero counter, so there is never a false negative.

Remote requests present an address on the query port. A combinational answer says whether this node might hold any block of that region. Each counter is sized so that it can count every block the cache can hold, so it cannot overflow. An eviction that finds its counter already at zero is reported on an error output.

Top module: `region_presence_filter`

## Requirements
- R1: The region tag is address bits [ADDR_W-1:REGION_LG]. The offset bits below REGION_LG never change which counter an access selects.
- R2: The counter index is the XOR of consecutive IDX_W-bit slices of the tag. The first slice starts at tag bit 0, and the last slice is zero-padded above the tag's top bit. So tag bit k feeds index bit k mod IDX_W.
- R3: An allocation raises the selected counter by one, and the query reflects the change from the next clock cycle.
- R4: An eviction lowers the selected counter by one when that counter is non-zero.
- R5: qry_maybe_o is 1 exactly when the counter selected by qry_addr is non-zero, in the same cycle, with no register in the path.
- R6: While any block of a region is resident, a query for that region returns 1. Another region that folds to the same index also returns 1.
- R7: An allocation and an eviction in the same cycle that select the same counter cancel. The counter is unchanged and no underflow is reported, even at zero.
- R8: An eviction that is not cancelled and selects a counter at zero leaves the counter at zero. It raises underflow_o for exactly the next cycle.
- R9: After reset every counter is zero, every query returns 0 and underflow_o is 0.
- R10: An allocation and an eviction in the same cycle that select different counters both take effect.
- R11: Counters are $clog2(CACHE_BLOCKS+1) bits wide. A single counter can reach CACHE_BLOCKS and return to zero without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | A block is being allocated this cycle |
| alloc_addr | input | ADDR_W | Address of the allocated block |
| evict_vld | input | 1 | A block is being evicted this cycle |
| evict_addr | input | ADDR_W | Address of the evicted block |
| qry_addr | input | ADDR_W | Address of the remote query |
| qry_maybe_o | output | 1 | 1 when the queried region may have a cached block |
| underflow_o | output | 1 | One-cycle pulse: an eviction hit a zero counter |

## Verification
The bench builds the block with a 20-bit address, 64-byte regions and a 16-entry table, so the tag folds from four slices, one of them padded. It sets CACHE_BLOCKS to 7, which gives 3-bit counters. With these values a single counter can be driven to its full value and back with little effort. Aliasing tags, cancelling pairs and evictions at zero are easy to hit both in directed steps and in a long randomized stream.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

  // Per-counter update command produced by the index decoders.
  typedef struct packed {
    logic inc;
    logic dec;
  } rpf_cmd_t;

  // Width needed to hold every value from 0 to max_count inclusive.
  function automatic int unsigned cnt_bits(input int unsigned max_count);
    return (max_count < 1) ? 1 : $clog2(max_count + 1);
  endfunction

endpackage

// File: rtl/rpf_fold.sv
module rpf_fold #(
  parameter int unsigned TAG_W = 18,
  parameter int unsigned IDX_W = 8
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned NSLICE = (TAG_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = NSLICE * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] acc [NSLICE+1];

  assign padded = PAD_W'(tag_i);
  assign acc[0] = '0;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign acc[s+1] = acc[s] ^ padded[s*IDX_W +: IDX_W];
  end

  assign idx_o = acc[NSLICE];
endmodule

// File: rtl/rpf_counter_cell.sv
module rpf_counter_cell
  import rpf_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rpf_cmd_t cmd_i,
  output logic     nonzero_o,
  output logic     underflow_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Opposing commands cancel; only a lone command enables the register.
  assign cnt_en = cmd_i.inc ^ cmd_i.dec;

  always_comb begin
    cnt_d       = cnt_q;
    underflow_o = 1'b0;
    unique case ({cmd_i.inc, cmd_i.dec})
      2'b10: cnt_d = cnt_q + CNT_W'(1);
      2'b01: begin
        if (cnt_q == '0) underflow_o = 1'b1;
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nonzero_o = (cnt_q != '0);
endmodule

// File: rtl/region_presence_filter.sv
module region_presence_filter
  import rpf_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned REGION_LG    = 14,
  parameter int unsigned IDX_W        = 8,
  parameter int unsigned CACHE_BLOCKS = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              evict_vld,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_maybe_o,
  output logic              underflow_o
);
  localparam int unsigned TAG_W = ADDR_W - REGION_LG;
  localparam int unsigned NCNT  = 1 << IDX_W;
  localparam int unsigned CNT_W = cnt_bits(CACHE_BLOCKS);

  logic [IDX_W-1:0] a_idx, e_idx, q_idx;
  logic [NCNT-1:0]  nz_vec;
  logic [NCNT-1:0]  uf_vec;
  logic             uf_d, uf_q;
  logic             unused_offsets;

  assign unused_offsets = ^{alloc_addr[REGION_LG-1:0], evict_addr[REGION_LG-1:0],
                            qry_addr[REGION_LG-1:0]};

  rpf_fold #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_fold_alloc (
    .tag_i(alloc_addr[ADDR_W-1:REGION_LG]), .idx_o(a_idx));
  rpf_fold #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_fold_evict (
    .tag_i(evict_addr[ADDR_W-1:REGION_LG]), .idx_o(e_idx));
  rpf_fold #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_fold_qry (
    .tag_i(qry_addr[ADDR_W-1:REGION_LG]),   .idx_o(q_idx));

  for (genvar i = 0; i < NCNT; i++) begin : g_cell
    rpf_cmd_t cmd;
    assign cmd.inc = alloc_vld && (a_idx == IDX_W'(i));
    assign cmd.dec = evict_vld && (e_idx == IDX_W'(i));
    rpf_counter_cell #(.CNT_W(CNT_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (cmd),
      .nonzero_o  (nz_vec[i]),
      .underflow_o(uf_vec[i])
    );
  end

  assign uf_d = |uf_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_q <= 1'b0;
    else        uf_q <= uf_d;
  end

  assign underflow_o = uf_q;
  assign qry_maybe_o = nz_vec[q_idx];
endmodule

// File: rtl/rpf_checker.sv
module rpf_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned REGION_LG = 14,
  parameter int unsigned IDX_W     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  alloc_vld,
  input logic [ADDR_W-1:0]     alloc_addr,
  input logic                  evict_vld,
  input logic [ADDR_W-1:0]     evict_addr,
  input logic                  underflow_o,
  input logic [(1<<IDX_W)-1:0] cnt_nz
);
  localparam int unsigned TAG_W = ADDR_W - REGION_LG;

  logic [IDX_W-1:0] ai, ei;
  logic             same;

  rpf_fold #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_ca (
    .tag_i(alloc_addr[ADDR_W-1:REGION_LG]), .idx_o(ai));
  rpf_fold #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_ce (
    .tag_i(evict_addr[ADDR_W-1:REGION_LG]), .idx_o(ei));

  assign same = alloc_vld && evict_vld && (ai == ei);

  // R3: a lone allocation leaves its counter non-zero.
  a_r3_alloc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && !same) |=> cnt_nz[$past(ai)]);

  // R10: differing indices, the allocation still lands.
  a_r10_split_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && evict_vld && (ai != ei)) |=> cnt_nz[$past(ai)]);

  // R7: a cancelling pair keeps the counter's zero state.
  a_r7_cancel_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    same |=> (cnt_nz[$past(ai)] == $past(cnt_nz[ai])));

  // R7: a cancelling pair never reports underflow.
  a_r7_cancel_no_uf: assert property (@(posedge clk) disable iff (!rst_n)
    same |=> !underflow_o);

  // R8: an underflow pulse has a lone eviction at a zero counter behind it.
  a_r8_uf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> $past(evict_vld && !same && !cnt_nz[ei]));

  // R8: a lone eviction at zero is always reported.
  a_r8_uf_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_vld && !same && !cnt_nz[ei]) |=> underflow_o);
endmodule

bind region_presence_filter rpf_checker #(
  .ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .IDX_W(IDX_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_vld  (alloc_vld),
  .alloc_addr (alloc_addr),
  .evict_vld  (evict_vld),
  .evict_addr (evict_addr),
  .underflow_o(underflow_o),
  .cnt_nz     (nz_vec)
);

// File: tb/region_presence_filter_tb_top.sv
module region_presence_filter_tb_top;
  localparam int ADDR_W = 20;
  localparam int RLG    = 6;
  localparam int IDX_W  = 4;
  localparam int BLKS   = 7;
  localparam int TAG_W  = ADDR_W - RLG;
  localparam int NCNT   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_vld = 1'b0, evict_vld = 1'b0;
  logic [ADDR_W-1:0] alloc_addr = '0, evict_addr = '0, qry_addr = '0;
  logic              qry_maybe_o, underflow_o;

  int  n_vec = 0, n_bad = 0;
  int  ref_cnt [NCNT];
  bit  exp_uf = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  region_presence_filter #(.ADDR_W(ADDR_W), .REGION_LG(RLG), .IDX_W(IDX_W),
                           .CACHE_BLOCKS(BLKS)) dut_i (.*);

  // Index from the bit-level rule: tag bit k feeds index bit k mod IDX_W.
  function automatic int href(input logic [TAG_W-1:0] t);
    logic [IDX_W-1:0] h = '0;
    for (int k = 0; k < TAG_W; k++) h[k % IDX_W] ^= t[k];
    return int'(h);
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t,
                                           input logic [RLG-1:0] off);
    return {t, off};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive, compare outputs against the model, then advance the model.
  task automatic step(input string req, input bit av, input logic [ADDR_W-1:0] aa,
                      input bit ev, input logic [ADDR_W-1:0] ea,
                      input logic [ADDR_W-1:0] qa);
    int ai, ei;
    @(negedge clk);
    alloc_vld = av; alloc_addr = aa; evict_vld = ev; evict_addr = ea; qry_addr = qa;
    #1;
    chk({req, " query"}, qry_maybe_o, ref_cnt[href(qa[ADDR_W-1:RLG])] != 0);
    chk({req, " underflow R8"}, underflow_o, exp_uf);
    ai = href(aa[ADDR_W-1:RLG]);
    ei = href(ea[ADDR_W-1:RLG]);
    exp_uf = 1'b0;
    if (!(av && ev && ai == ei)) begin
      if (av) ref_cnt[ai]++;
      if (ev) begin
        if (ref_cnt[ei] == 0) exp_uf = 1'b1;
        else                  ref_cnt[ei]--;
      end
    end
  endtask

  task automatic idle(input string req, input logic [ADDR_W-1:0] qa);
    step(req, 0, '0, 0, '0, qa);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [TAG_W-1:0] res [$];
    for (int i = 0; i < NCNT; i++) ref_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: everything zero after reset.
    for (int i = 0; i < NCNT; i++) idle("R9", mk(TAG_W'(i), '0));

    // R3/R5: allocate, visible next cycle.
    step("R3", 1, mk(14'h0123, 6'h05), 0, '0, mk(14'h0123, 6'h00));
    idle("R3 R5", mk(14'h0123, 6'h3F));
    // R1: offset bits do not matter; other region with different index is 0.
    idle("R1", mk(14'h0123, 6'h2A));
    idle("R5", mk(14'h0124, 6'h00));
    // R6: alias tag (flip bit 0 of two slices) also reports 1.
    idle("R6", mk(14'h0123 ^ 14'h0011, 6'h00));
    // R2: padded top slice, bit 12 folds onto index bit 0.
    step("R2", 1, mk(14'h1000, 6'h00), 0, '0, mk(14'h0001, 6'h00));
    idle("R2", mk(14'h0001, 6'h00));
    idle("R2", mk(14'h0002, 6'h00));
    idle("R2", mk(14'h2000, 6'h00));
    // R4: evict both blocks.
    step("R4", 0, '0, 1, mk(14'h0123, 6'h11), mk(14'h0123, 6'h00));
    step("R4", 0, '0, 1, mk(14'h1000, 6'h00), mk(14'h0123, 6'h00));
    idle("R4", mk(14'h0001, 6'h00));
    // R8: evict at zero.
    step("R8", 0, '0, 1, mk(14'h0077, 6'h00), mk(14'h0077, 6'h00));
    idle("R8", mk(14'h0077, 6'h00));
    idle("R8", mk(14'h0077, 6'h00));
    // R7: cancel at zero, then cancel at one.
    step("R7", 1, mk(14'h0040, 6'h00), 1, mk(14'h0040, 6'h01), mk(14'h0040, 6'h00));
    idle("R7", mk(14'h0040, 6'h00));
    step("R7", 1, mk(14'h0040, 6'h00), 0, '0, mk(14'h0040, 6'h00));
    step("R7", 1, mk(14'h0051, 6'h00), 1, mk(14'h0040, 6'h00), mk(14'h0040, 6'h00));
    idle("R7", mk(14'h0040, 6'h00));
    // R10: different counters in one cycle.
    step("R10", 1, mk(14'h0002, 6'h00), 1, mk(14'h0040, 6'h00), mk(14'h0002, 6'h00));
    idle("R10", mk(14'h0040, 6'h00));
    idle("R10", mk(14'h0002, 6'h00));
    step("R10", 0, '0, 1, mk(14'h0002, 6'h00), mk(14'h0002, 6'h00));
    idle("R10", mk(14'h0002, 6'h00));
    // R11: one counter to full count and back.
    for (int i = 0; i < BLKS; i++)
      step("R11", 1, mk(TAG_W'(14'h0300 + 16'(i) * 16'h0011), 6'h00), 0, '0,
           mk(14'h0300, 6'h00));
    for (int i = 0; i < BLKS; i++)
      step("R11", 0, '0, 1, mk(14'h0300, 6'h00), mk(14'h0300, 6'h00));
    idle("R11", mk(14'h0300, 6'h00));
    idle("R11 R8", mk(14'h0300, 6'h00));

    // Randomized stream with resident-block tracking.
    for (int n = 0; n < 4000; n++) begin
      bit av, ev;
      logic [TAG_W-1:0] at, et, qt;
      av = (res.size() < BLKS - 1) && ($urandom % 2 == 0);
      at = TAG_W'($urandom % 96);
      ev = 1'b0; et = '0;
      if (res.size() > 0 && ($urandom % 2 == 0)) begin
        int k = $urandom % res.size();
        ev = 1'b1; et = res[k]; res.delete(k);
      end else if ($urandom % 16 == 0) begin
        ev = 1'b1; et = TAG_W'($urandom % 96);
      end
      if (av) res.push_back(at);
      qt = (res.size() > 0 && ($urandom % 2 == 0)) ? res[$urandom % res.size()]
                                                   : TAG_W'($urandom % 96);
      step("R6 R5 random", av, mk(at, 6'($urandom)), ev, mk(et, 6'($urandom)),
           mk(qt, 6'($urandom)));
    end
    idle("R8 tail", '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule